// File: doc/BRIEF.md
# Eight-Lane Float Compare-and-Select Unit

This block is a vector datapath stage that works on 256-bit words, each viewed as eight independent IEEE-754 single-precision lanes. One operation is issued per cycle, chosen by an operation code. The first kind of operation is a lane-wise comparison under a predicate code. It yields a mask in which every lane is either all ones or all zeros. The other kinds are full-word bitwise operations: AND, OR, XOR, an AND-NOT that inverts its first operand, and a bitwise blend that takes each result bit from a "then" or an "else" operand under a mask operand.

A typical use is branch-free conditional assignment. A compare produces a lane mask, and a following select uses that mask to merge two candidate vectors. Comparisons are ordered and quiet: any lane that holds a NaN on either side compares false under every predicate, including not-equal. Positive and negative zero compare equal. The result is registered, and a valid strobe travels beside it with one cycle of latency. A new operation can be accepted on every cycle.

Top module: `vlane_cmpsel_unit`

## Requirements
- R1: After a cycle with `rst` high, `out_valid` is 0 and `out_result` is all zeros. Outside reset, `out_valid` equals the value `in_valid` had at the previous clock edge.
- R2: When `in_valid` is low at a clock edge, `out_result` keeps its value, whatever the other inputs do.
- R3: With `op_sel`=0 (compare), lane i occupies bits [32i+31:32i] of every operand and of the result. That result lane is 32'hFFFFFFFF when `src_a` lane i relates to `src_b` lane i under `pred_sel`, and 0 otherwise. Each lane is judged independently of the others.
- R4: Predicate 0 is equal and predicate 1 is not-equal. +0 (32'h00000000) and -0 (32'h80000000) compare equal. Any two other non-NaN patterns are equal only if they are bit-identical.
- R5: Predicates 2, 3, 4 and 5 are less-than, less-or-equal, greater-than and greater-or-equal. They follow numeric order, including denormals and ±infinity (exponent 255, fraction 0).
- R6: A lane in which either input is NaN (exponent field 255, fraction nonzero) gives a zero result lane under all six predicates.
- R7: `op_sel` values 1, 2 and 3 give the bitwise AND, OR and XOR of `src_a` and `src_b` over the full 256 bits.
- R8: `op_sel`=4 gives (NOT `src_a`) AND `src_b`.
- R9: `op_sel`=5 gives (`src_a` AND `src_b`) OR ((NOT `src_a`) AND `src_c`). Here `src_a` is the mask, `src_b` is "then" and `src_c` is "else".
- R10: `op_sel` values 6 and 7 give an all-zero result. So does a compare with `pred_sel` value 6 or 7.
- R11: Operations issued on consecutive cycles each produce their own result on the following cycle, so the throughput is one operation per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issue strobe |
| op_sel | input | 3 | Operation code (0 compare, 1 AND, 2 OR, 3 XOR, 4 AND-NOT, 5 select) |
| pred_sel | input | 3 | Compare predicate (0 EQ, 1 NE, 2 LT, 3 LE, 4 GT, 5 GE) |
| src_a | input | 256 | First operand; the mask for select |
| src_b | input | 256 | Second operand; the "then" value for select |
| src_c | input | 256 | "Else" value for select, unused by other operations |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | 256 | Registered result |

## Verification
The bench aims at signed zeros, NaNs of both signs, infinities, denormals and pairs of negative values. A design that compared raw integers would order negative lanes backwards. One that compared bit patterns for equality would call +0 and -0 different. One that derived not-equal by inverting equal would report NaN lanes as unequal. Operand-order mistakes in AND-NOT and select show up on random words as flipped bits. Idle cycles with changing inputs expose a result register that loads when no operation was issued. A long back-to-back stream mixing all codes, including the unused ones, catches a result that lags by a cycle or leaks from one lane into its neighbour.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    localparam int SP_W = 32;

    typedef enum logic [2:0] {
        OP_CMP  = 3'd0,
        OP_AND  = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_ANDN = 3'd4,
        OP_SEL  = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        PR_EQ = 3'd0,
        PR_NE = 3'd1,
        PR_LT = 3'd2,
        PR_LE = 3'd3,
        PR_GT = 3'd4,
        PR_GE = 3'd5
    } pred_e;

    typedef struct packed {
        logic        sign;
        logic [7:0]  expo;
        logic [22:0] frac;
    } sp_t;

    function automatic logic sp_is_nan(sp_t x);
        return (x.expo == 8'hFF) && (x.frac != '0);
    endfunction

    function automatic logic sp_is_zero(sp_t x);
        return (x.expo == 8'h00) && (x.frac == '0);
    endfunction

    function automatic logic [30:0] sp_mag(sp_t x);
        return {x.expo, x.frac};
    endfunction

endpackage

// File: rtl/vcmp_lane.sv
module vcmp_lane
    import vcmp_pkg::*;
(
    input  sp_t   lhs,
    input  sp_t   rhs,
    input  pred_e pred,
    output logic  hit
);
    logic unordered;
    logic zeros;
    logic same;
    logic a_below;
    logic b_below;
    logic less;
    logic more;

    always_comb begin
        unordered = sp_is_nan(lhs) | sp_is_nan(rhs);
        zeros     = sp_is_zero(lhs) & sp_is_zero(rhs);
        same      = !unordered && (zeros || (lhs == rhs));
        a_below   = sp_mag(lhs) < sp_mag(rhs);
        b_below   = sp_mag(rhs) < sp_mag(lhs);
        less      = 1'b0;
        if (!unordered && !zeros) begin
            if (lhs.sign != rhs.sign) begin
                less = lhs.sign;
            end else if (lhs.sign) begin
                less = b_below;
            end else begin
                less = a_below;
            end
        end
        more = !unordered && !same && !less;
        case (pred)
            PR_EQ:   hit = same;
            PR_NE:   hit = !unordered && !same;
            PR_LT:   hit = less;
            PR_LE:   hit = less | same;
            PR_GT:   hit = more;
            PR_GE:   hit = more | same;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/vcmp_mask_array.sv
module vcmp_mask_array
    import vcmp_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [LANES*SP_W-1:0] lhs_vec,
    input  logic [LANES*SP_W-1:0] rhs_vec,
    input  pred_e                 pred,
    output logic [LANES*SP_W-1:0] mask
);
    logic [LANES-1:0] hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vcmp_lane u_lane (
            .lhs  (sp_t'(lhs_vec[g*SP_W +: SP_W])),
            .rhs  (sp_t'(rhs_vec[g*SP_W +: SP_W])),
            .pred (pred),
            .hit  (hit[g])
        );
        assign mask[g*SP_W +: SP_W] = {SP_W{hit[g]}};
    end
endmodule

// File: rtl/vcmp_bitwise.sv
module vcmp_bitwise
    import vcmp_pkg::*;
#(
    parameter int W = 256
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_ANDN: res = ~a & b;
            OP_SEL:  res = (a & b) | (~a & c);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/vlane_cmpsel_unit.sv
module vlane_cmpsel_unit
    import vcmp_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [2:0]            op_sel,
    input  logic [2:0]            pred_sel,
    input  logic [LANES*32-1:0]   src_a,
    input  logic [LANES*32-1:0]   src_b,
    input  logic [LANES*32-1:0]   src_c,
    output logic                  out_valid,
    output logic [LANES*32-1:0]   out_result
);
    localparam int VEC_W = LANES * SP_W;

    op_e              op;
    pred_e            pred;
    logic [VEC_W-1:0] cmp_mask;
    logic [VEC_W-1:0] logic_res;
    logic [VEC_W-1:0] next_res;
    logic [VEC_W-1:0] res_q;
    logic             vld_q;

    assign op   = op_e'(op_sel);
    assign pred = pred_e'(pred_sel);

    vcmp_mask_array #(.LANES(LANES)) u_cmp (
        .lhs_vec (src_a),
        .rhs_vec (src_b),
        .pred    (pred),
        .mask    (cmp_mask)
    );

    vcmp_bitwise #(.W(VEC_W)) u_bits (
        .op  (op),
        .a   (src_a),
        .b   (src_b),
        .c   (src_c),
        .res (logic_res)
    );

    assign next_res = (op == OP_CMP) ? cmp_mask : logic_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= next_res;
            end
        end
    end

    assign out_valid  = vld_q;
    assign out_result = res_q;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_no_valid_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));
    assert_unused_op_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel > 3'd5) |=> (out_result == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        assert_full_lane_mask_R3: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 3'd0) |=>
            (out_result[g*SP_W +: SP_W] == '0 || out_result[g*SP_W +: SP_W] == '1));
        assert_nan_false_R6: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 3'd0 &&
             (sp_is_nan(sp_t'(src_a[g*SP_W +: SP_W])) || sp_is_nan(sp_t'(src_b[g*SP_W +: SP_W]))))
            |=> (out_result[g*SP_W +: SP_W] == '0));
    end
endmodule

// File: tb/vlane_cmpsel_unit_tb.sv
module vlane_cmpsel_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   op_sel = '0;
    logic [2:0]   pred_sel = '0;
    logic [255:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic [255:0] src_c = '0;
    logic         out_valid;
    logic [255:0] out_result;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit checking = 0;
    bit done = 0;
    string cur_tag = "R1";

    logic         m_valid = 1'b0;
    logic [255:0] m_res = '0;
    string        m_tag = "R1";

    vlane_cmpsel_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .pred_sel(pred_sel), .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .out_valid(out_valid), .out_result(out_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit is_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic longint key(logic [31:0] x);
        longint m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction

    function automatic bit rel(logic [31:0] x, logic [31:0] y, logic [2:0] p);
        longint kx, ky;
        if (is_nan(x) || is_nan(y)) return 1'b0;
        kx = key(x);
        ky = key(y);
        case (p)
            3'd0: return kx == ky;
            3'd1: return kx != ky;
            3'd2: return kx < ky;
            3'd3: return kx <= ky;
            3'd4: return kx > ky;
            3'd5: return kx >= ky;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [255:0] ref_op(logic [2:0] o, logic [2:0] p,
                                            logic [255:0] a, logic [255:0] b, logic [255:0] c);
        logic [255:0] r = '0;
        case (o)
            3'd0: for (int i = 0; i < 8; i++)
                      r[i*32 +: 32] = rel(a[i*32 +: 32], b[i*32 +: 32], p) ? 32'hFFFFFFFF : 32'h0;
            3'd1: r = a & b;
            3'd2: r = a | b;
            3'd3: r = a ^ b;
            3'd4: r = ~a & b;
            3'd5: r = (a & b) | (~a & c);
            default: r = '0;
        endcase
        return r;
    endfunction

    // reference model, updated at each rising edge from the stable inputs
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_valid = 1'b0;
            m_res   = '0;
            m_tag   = "R1";
        end else begin
            m_valid = in_valid;
            if (in_valid) begin
                m_res = ref_op(op_sel, pred_sel, src_a, src_b, src_c);
                m_tag = cur_tag;
            end else begin
                m_tag = "R2";
            end
        end
        if (cycles > WATCHDOG && !done) begin
            failures++;
            $display("FAIL R11 watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // comparison on every falling edge
    always @(negedge clk) begin
        if (checking) begin
            checks++;
            if (out_valid !== m_valid) begin
                failures++;
                $display("FAIL R1 out_valid: actual=%0b expected=%0b", out_valid, m_valid);
            end
            checks++;
            if (out_result !== m_res) begin
                failures++;
                $display("FAIL %s out_result: actual=%h expected=%h", m_tag, out_result, m_res);
            end
        end
    end

    task automatic issue(bit v, logic [2:0] o, logic [2:0] p,
                         logic [255:0] a, logic [255:0] b, logic [255:0] c, string tag);
        @(negedge clk);
        in_valid = v; op_sel = o; pred_sel = p;
        src_a = a; src_b = b; src_c = c;
        cur_tag = tag;
    endtask

    function automatic logic [255:0] rnd_word();
        logic [255:0] w;
        for (int i = 0; i < 8; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    function automatic logic [31:0] special();
        case ($urandom_range(0, 11))
            0: return 32'h00000000;
            1: return 32'h80000000;
            2: return 32'h3F800000;
            3: return 32'hBF800000;
            4: return 32'h7F800000;
            5: return 32'hFF800000;
            6: return 32'h7FC00000;
            7: return 32'hFFC00001;
            8: return 32'h00000001;
            9: return 32'h80000001;
            10: return 32'h40000000;
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [255:0] special_word();
        logic [255:0] w;
        for (int i = 0; i < 8; i++) w[i*32 +: 32] = special();
        return w;
    endfunction

    logic [255:0] za, zb, oa, ob, na, nb;

    initial begin
        // R1: reset state, checked after the first edge in reset
        @(posedge clk);
        checking = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R4: zeros, identical values, NaN vs number for equal and not-equal
        za = {32'h80000000, 32'hBF800000, 32'h7F800000, 32'h3F800000,
              32'h7FC00000, 32'h3F800000, 32'h80000000, 32'h00000000};
        zb = {32'h00000000, 32'hBF800000, 32'h7F800000, 32'h40000000,
              32'h3F800000, 32'h3F800000, 32'h00000000, 32'h80000000};
        issue(1, 3'd0, 3'd0, za, zb, '0, "R4");
        issue(1, 3'd0, 3'd1, za, zb, '0, "R4");

        // R5: ordering across signs, negatives, denormals, infinities
        oa = {32'h40400000, 32'h7F800000, 32'h80000000, 32'h00000001,
              32'h3F800000, 32'hFF800000, 32'hBF800000, 32'hC0000000};
        ob = {32'h40400000, 32'h7F800000, 32'h80000001, 32'h00000000,
              32'h40000000, 32'hF0000000, 32'hC0000000, 32'hBF800000};
        for (int p = 2; p <= 5; p++) issue(1, 3'd0, 3'(p), oa, ob, '0, "R5");

        // R6: NaN in either operand under every predicate
        na = {32'h7FC00000, 32'h3F800000, 32'hFFC00001, 32'h00000000,
              32'h7F800001, 32'h7FFFFFFF, 32'h3F800000, 32'h7FC00000};
        nb = {32'h3F800000, 32'h7FC00000, 32'hFFC00001, 32'hFF800001,
              32'h00000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FC00000};
        for (int p = 0; p <= 5; p++) issue(1, 3'd0, 3'(p), na, nb, '0, "R6");

        // R7, R8, R9: bitwise operations on random words
        for (int k = 0; k < 4; k++) begin
            issue(1, 3'd1, 3'd0, rnd_word(), rnd_word(), rnd_word(), "R7");
            issue(1, 3'd2, 3'd0, rnd_word(), rnd_word(), rnd_word(), "R7");
            issue(1, 3'd3, 3'd0, rnd_word(), rnd_word(), rnd_word(), "R7");
            issue(1, 3'd4, 3'd0, rnd_word(), rnd_word(), rnd_word(), "R8");
            issue(1, 3'd5, 3'd0, rnd_word(), rnd_word(), rnd_word(), "R9");
        end

        // R2: idle cycles with changing inputs must not disturb the result
        for (int k = 0; k < 5; k++) issue(0, 3'd1, 3'd0, rnd_word(), rnd_word(), rnd_word(), "R2");

        // R10: unused operation codes and unused predicates
        issue(1, 3'd6, 3'd0, rnd_word(), rnd_word(), rnd_word(), "R10");
        issue(1, 3'd7, 3'd0, rnd_word(), rnd_word(), rnd_word(), "R10");
        issue(1, 3'd0, 3'd6, za, za, '0, "R10");
        issue(1, 3'd0, 3'd7, oa, oa, '0, "R10");

        // R3 and R11: back-to-back mixed stream with special lane values
        for (int k = 0; k < 600; k++) begin
            issue($urandom_range(0, 4) != 0, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                  special_word(), special_word(), rnd_word(), "R11");
        end
        for (int k = 0; k < 200; k++) begin
            issue(1, 3'd0, 3'($urandom_range(0, 5)), special_word(), special_word(), '0, "R3");
        end

        issue(0, 3'd0, 3'd0, '0, '0, '0, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule